// File: doc/BRIEF.md
# Quarter-Rate Carrier QPSK Modulator

This block turns a serial bit stream into a real-valued QPSK passband sample stream, one sample per clock. Incoming bits are taken in pairs. The earlier bit of each pair drives the in-phase rail and the later bit drives the quadrature rail. Each bit becomes a signed unit symbol. Each rail then passes through a 37-tap root-raised-cosine interpolator (roll-off 0.35, three symbols either side of the peak), which is split into six polyphase branches, so every symbol yields six filtered samples.

The carrier runs at exactly one quarter of the sample rate. Its cosine and sine therefore take only the values +1, 0 and -1. The mix `I*cos - Q*sin` reduces to choosing one rail per sample and possibly negating it, so no multiplier is used anywhere in the datapath. The block sets the pace itself: it raises `bit_ready` for one clock every third clock, and the source must present the next bit on `bit_in` during that clock.

Top module: `qpsk_fs4_mod`

## Requirements
- R1: After reset the symbol history holds no symbols and both phase counters are 0. While reset is held, and for the first four clocks after its release, `samp_out` is 0.
- R2: `bit_ready` is high in the first clock after reset release and then exactly once every 3 clocks. Two consecutive ready cycles are always 3 clocks apart.
- R3: The bit accepted on the first ready cycle of each pair (the cycle in which the 6-step sample counter is 0) goes to the I rail. The bit accepted on the next ready cycle (counter 3) goes to the Q rail.
- R4: A bit value 0 maps to symbol +1 and a bit value 1 maps to symbol -1, that is, symbol = 1 - 2*bit.
- R5: Each rail output at sample index m equals sum over n of h[n]*x[(m-n)/6]. The sum runs over the 37 signed 12-bit coefficients h[0..36] and only over terms where (m-n) is a non-negative multiple of 6. It is evaluated as branch m mod 6 of a six-way polyphase split, where branch 0 holds 7 taps and every other branch holds 6.
- R6: At sample index m the output is I for m mod 4 = 0, -Q for m mod 4 = 1, -I for m mod 4 = 2, and +Q for m mod 4 = 3.
- R7: Symbol k enters the filter at the clock edge that ends the Q-bit cycle. Its first filtered sample (m = 6k) appears on `samp_out` one edge later. Sample m therefore appears after the (m+5)-th rising edge following reset release.
- R8: `|samp_out|` never exceeds the sum of the absolute coefficient values, and the accumulator never overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial data bit, sampled while bit_ready is high |
| bit_ready | output | 1 | Strobe requesting the next bit in this cycle |
| samp_out | output | 19 | Signed passband sample, two's complement |

## Verification
The checker tests the timing skeleton on every cycle: the three-clock spacing of `bit_ready`, the branch counter restarting on each new symbol, the one-step advance of the carrier phase, the quiet output just after reset, and the amplitude bound. Only the bench scenarios can show that the numbers are right. That covers which bit lands on which rail, the bit-to-sign mapping, the polyphase arithmetic against a direct upsample-and-convolve model, and the carrier sign pattern. These are exercised with constant-zero, constant-one, alternating and pseudo-random bit streams.

// File: rtl/qpsk_fs4_pkg.sv
package qpsk_fs4_pkg;
  localparam int OSR   = 6;
  localparam int TAPS  = 37;
  localparam int CW    = 12;
  localparam int DEPTH = (TAPS + OSR - 1) / OSR;
  localparam int PHW   = $clog2(OSR);
  localparam int OW    = CW + $clog2(TAPS) + 1;
  localparam int HALF  = OSR / 2;

  // Root-raised-cosine, roll-off 0.35, 6 samples per symbol, span +/-3 symbols.
  localparam logic signed [CW-1:0] COEF [TAPS] = '{
    -12'sd8,   -12'sd18,  -12'sd22,  -12'sd15,  12'sd5,    12'sd30,
     12'sd55,   12'sd60,   12'sd35,  -12'sd20,  -12'sd95,  -12'sd150,
    -12'sd150, -12'sd60,   12'sd140,  12'sd430,  12'sd750,  12'sd1000,
     12'sd1096,
     12'sd1000, 12'sd750,  12'sd430,  12'sd140, -12'sd60,  -12'sd150,
    -12'sd150, -12'sd95,  -12'sd20,   12'sd35,   12'sd60,   12'sd55,
     12'sd30,   12'sd5,   -12'sd15,  -12'sd22,  -12'sd18,  -12'sd8
  };

  // One polyphase branch: add or subtract each live tap, no multiplier.
  function automatic logic signed [OW-1:0] branch_sum(
    input logic [DEPTH-1:0] sbit,
    input logic [DEPTH-1:0] sval,
    input logic [PHW-1:0]   br
  );
    logic signed [OW-1:0] acc;
    int idx;
    acc = '0;
    for (int j = 0; j < DEPTH; j++) begin
      idx = int'(br) + OSR * j;
      if (idx < TAPS && sval[j]) begin
        if (sbit[j]) acc = acc - OW'(COEF[idx]);
        else         acc = acc + OW'(COEF[idx]);
      end
    end
    return acc;
  endfunction

  function automatic int abs_bound();
    int s;
    s = 0;
    for (int n = 0; n < TAPS; n++)
      s += (COEF[n] < 0) ? -int'(COEF[n]) : int'(COEF[n]);
    return s;
  endfunction
endpackage

// File: rtl/qpsk_sym_seq.sv
module qpsk_sym_seq
  import qpsk_fs4_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_in,
  output logic           bit_ready,
  output logic           sym_shift,
  output logic           sym_i,
  output logic           sym_q,
  output logic [PHW-1:0] branch_idx
);
  logic [PHW-1:0] ph;
  logic           i_hold;
  logic           i_slot;
  logic           q_slot;

  assign i_slot    = (ph == '0);
  assign q_slot    = (ph == PHW'(HALF));
  assign bit_ready = i_slot || q_slot;
  assign sym_shift = q_slot;
  assign sym_i     = i_hold;
  assign sym_q     = bit_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= '0;
      i_hold     <= 1'b0;
      branch_idx <= '0;
    end else begin
      ph <= (ph == PHW'(OSR - 1)) ? '0 : ph + 1'b1;
      if (i_slot) i_hold <= bit_in;
      if (sym_shift)                       branch_idx <= '0;
      else if (branch_idx == PHW'(OSR - 1)) branch_idx <= '0;
      else                                 branch_idx <= branch_idx + 1'b1;
    end
  end
endmodule

// File: rtl/qpsk_poly_rrc.sv
module qpsk_poly_rrc
  import qpsk_fs4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic                 sym,
  input  logic [PHW-1:0]       branch_idx,
  output logic signed [OW-1:0] y
);
  logic [DEPTH-1:0] sbit;
  logic [DEPTH-1:0] sval;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbit <= '0;
      sval <= '0;
    end else if (shift) begin
      sbit <= {sbit[DEPTH-2:0], sym};
      sval <= {sval[DEPTH-2:0], 1'b1};
    end
  end

  assign y = branch_sum(sbit, sval, branch_idx);
endmodule

// File: rtl/qpsk_fs4_mixer.sv
module qpsk_fs4_mixer
  import qpsk_fs4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [OW-1:0] y_i,
  input  logic signed [OW-1:0] y_q,
  output logic [1:0]           carrier_ph,
  output logic signed [OW-1:0] samp_out
);
  logic signed [OW-1:0] mixed;

  always_comb begin
    unique case (carrier_ph)
      2'd0:    mixed = y_i;
      2'd1:    mixed = -y_q;
      2'd2:    mixed = -y_i;
      default: mixed = y_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carrier_ph <= 2'd0;
      samp_out   <= '0;
    end else begin
      carrier_ph <= carrier_ph + 2'd1;
      samp_out   <= mixed;
    end
  end
endmodule

// File: rtl/qpsk_fs4_mod.sv
module qpsk_fs4_mod
  import qpsk_fs4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_in,
  output logic                 bit_ready,
  output logic signed [OW-1:0] samp_out
);
  logic           sym_shift;
  logic [1:0]     sym_bits;
  logic [PHW-1:0] branch_idx;
  logic [1:0]     carrier_ph;
  logic signed [OW-1:0] rail_y [2];

  qpsk_sym_seq seq_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_ready(bit_ready),
    .sym_shift(sym_shift), .sym_i(sym_bits[0]), .sym_q(sym_bits[1]),
    .branch_idx(branch_idx)
  );

  for (genvar r = 0; r < 2; r++) begin : g_rail
    qpsk_poly_rrc fir_i (
      .clk(clk), .rst_n(rst_n), .shift(sym_shift), .sym(sym_bits[r]),
      .branch_idx(branch_idx), .y(rail_y[r])
    );
  end

  qpsk_fs4_mixer mix_i (
    .clk(clk), .rst_n(rst_n), .y_i(rail_y[0]), .y_q(rail_y[1]),
    .carrier_ph(carrier_ph), .samp_out(samp_out)
  );
endmodule

// File: rtl/qpsk_fs4_mod_chk.sv
module qpsk_fs4_mod_chk
  import qpsk_fs4_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_ready,
  input logic                 sym_shift,
  input logic [PHW-1:0]       branch_idx,
  input logic [1:0]           carrier_ph,
  input logic signed [OW-1:0] samp_out
);
  localparam int BOUND = abs_bound();

  logic [2:0] gap;
  logic       seen;
  logic [2:0] quiet;
  logic       past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '0; seen <= 1'b0; quiet <= '0; past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (bit_ready) begin gap <= '0; seen <= 1'b1; end
      else gap <= gap + 3'd1;
      if (quiet != 3'd7) quiet <= quiet + 3'd1;
    end
  end

  a_r2_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ready && seen) |-> gap == 3'(HALF - 1));
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet < 3'd5) |-> samp_out == '0);
  a_r5_branch_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sym_shift |=> branch_idx == '0);
  a_r6_carrier_step: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> carrier_ph == 2'($past(carrier_ph) + 2'd1));
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(samp_out) <= BOUND) && (int'(samp_out) >= -BOUND));
  a_r3_shift_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sym_shift |-> bit_ready);
endmodule

bind qpsk_fs4_mod qpsk_fs4_mod_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_ready(bit_ready), .sym_shift(sym_shift),
  .branch_idx(branch_idx), .carrier_ph(carrier_ph), .samp_out(samp_out)
);

// File: tb/qpsk_fs4_mod_tb_top.sv
`timescale 1ns/1ps
module qpsk_fs4_mod_tb_top;
  import qpsk_fs4_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bit_in;
  logic bit_ready;
  logic signed [OW-1:0] samp_out;

  qpsk_fs4_mod dut_i (.clk(clk), .rst_n(rst_n), .bit_in(bit_in),
                      .bit_ready(bit_ready), .samp_out(samp_out));

  int n_cmp = 0, n_bad = 0;
  int sym_i_q[$];
  int sym_q_q[$];
  int edges = 0;
  bit running = 1'b0;
  int max_abs = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Direct upsample-by-6 convolution, then the quarter-rate carrier (R4 R5 R6).
  function automatic int model(input int m);
    int ai, aq, t, k;
    ai = 0; aq = 0;
    if (m < 0) return 0;
    for (int n = 0; n < TAPS; n++) begin
      t = m - n;
      if (t >= 0 && t % OSR == 0) begin
        k = t / OSR;
        if (k < sym_i_q.size()) ai += int'(COEF[n]) * sym_i_q[k];
        if (k < sym_q_q.size()) aq += int'(COEF[n]) * sym_q_q[k];
      end
    end
    case (m % 4)
      0: return ai;
      1: return -aq;
      2: return -ai;
      default: return aq;
    endcase
  endfunction

  always @(posedge clk) if (running) edges++;

  // Monitor: compare each new output sample against the scoreboard model.
  always @(negedge clk) begin
    if (running && edges > 0) begin
      int m;
      m = edges - 5;
      if (int'(samp_out) > max_abs) max_abs = int'(samp_out);
      if (-int'(samp_out) > max_abs) max_abs = -int'(samp_out);
      if (m < 0)       chk("R1", int'(samp_out), 0);
      else if (m == 0) chk("R7", int'(samp_out), model(0));
      else             chk("R3 R4 R5 R6", int'(samp_out), model(m));
    end
  end

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pat[$];
    logic [15:0] lfsr;
    bit slot_q, first;
    int since;
    for (int i = 0; i < 40; i++) pat.push_back(0);
    for (int i = 0; i < 40; i++) pat.push_back(1);
    for (int i = 0; i < 40; i++) pat.push_back(i % 2);
    for (int i = 0; i < 40; i++) pat.push_back((i / 2) % 2);
    lfsr = 16'hACE1;
    for (int i = 0; i < 240; i++) begin
      pat.push_back(int'(lfsr[0]));
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end

    rst_n = 1'b0; bit_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", int'(samp_out), 0);
    rst_n = 1'b1;
    running = 1'b1;
    chk("R2", int'(bit_ready), 1);

    slot_q = 1'b0; first = 1'b1; since = 0;
    foreach (pat[p]) begin
      while (!bit_ready) begin @(negedge clk); since++; end
      if (!first) chk("R2", since, HALF);
      first = 1'b0;
      bit_in = pat[p][0];
      if (!slot_q) sym_i_q.push_back(1 - 2 * pat[p]);
      else         sym_q_q.push_back(1 - 2 * pat[p]);
      slot_q = !slot_q;
      @(negedge clk);
      since = 1;
    end
    running = 1'b0;
    chk("R8", int'(max_abs <= abs_bound()), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule